// File: doc/BRIEF.md
# Two-Step ADC Conversion Sequencer

This block is the digital control core of a multiplexed two-step 8-bit analog-to-digital converter. A read access starts a conversion. The access is both chip-select and read low at the same time. At that start the block latches the channel address and drives it to the analog multiplexer. It then times three phases with cycle counters: a tracking phase, a fine phase and a recovery phase.

At the end of tracking, the coarse comparator bank's 15-line thermometer code is encoded into the upper nibble of the result register. At the end of the fine phase, the residue bank's code is encoded into the lower nibble, and the interrupt output is asserted. A ready flag models an open-drain pin. When it is 1 the pin is pulled low; when it is 0 the pin is released.

Two read styles are supported, and the block tells them apart by how long the strobe is held. A short pulse reads the previous result at once while a new conversion runs (pipelined read). A strobe held through the conversion hides the bus until the new result is ready and then drives it (wait-state read). A start that arrives while the block is busy, including the recovery phase, is dropped and recorded in a sticky overrun flag.

Top module: `hf_adc_seq`

## Requirements
- R1: A start is a cycle in which cs_ni and rd_ni are both low after a cycle in which they were not both low, sampled while idle. At that edge addr_i is latched to mux_sel_o, which keeps the value until the next accepted start, whatever addr_i does.
- R2: Counting the sampling edge of an accepted start as edge 1, the coarse nibble is captured at edge TRACK_CYC+1 and the fine nibble at edge TRACK_CYC+FINE_CYC+1. int_no is still high after edge TRACK_CYC+FINE_CYC.
- R3: Each stage encodes its 15-line thermometer code (line i set for every level above i) as the number of lines set. The coarse stage gives data_o[7:4] and the fine stage gives data_o[3:0]. An all-clear code gives 0 and an all-set code gives 15.
- R4: If a code has a clear line below a set line, it is still encoded as its count of set lines. The stage's error flag (coarse_err_o or fine_err_o) is set at that stage's capture and stays until the next accepted start clears it.
- R5: int_no goes low at the fine capture edge. It returns high at the first edge that samples a rising cs_ni or rd_ni.
- R6: rdy_low_o becomes 1 at the edge that samples cs_ni falling. It returns to 0 at the edge that samples cs_ni rising, or at the fine capture edge.
- R7: A strobe held for PIPE_WIN sampled edges or more while tracking or fine conversion is in progress makes data_oe_o 0. data_oe_o goes back to 1, with the new result on data_o, from the fine capture edge onward.
- R8: While a strobe is low and not held as in R7, data_oe_o is 1 and data_o shows the result register. A short read therefore returns the previous conversion result.
- R9: A strobe beginning while busy (tracking, fine or recovery) leaves mux_sel_o and the conversion unchanged and sets overrun_o. overrun_o stays set until reset.
- R10: Counting the sampling edge of an accepted start as edge 1, a strobe sampled at edge TRACK_CYC+FINE_CYC+RECOV_CYC+1 is ignored. One sampled later is accepted.
- R11: After reset: data_oe_o 0, int_no 1, rdy_low_o 0, overrun_o and both error flags 0, mux_sel_o 0, result register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | CH_W | Channel address |
| coarse_therm_i | input | 15 | Coarse comparator thermometer code |
| fine_therm_i | input | 15 | Residue comparator thermometer code |
| mux_sel_o | output | CH_W | Latched channel to the analog multiplexer |
| data_o | output | 8 | Result register value |
| data_oe_o | output | 1 | Bus drive enable (0 = high impedance) |
| int_no | output | 1 | End of conversion, active low |
| rdy_low_o | output | 1 | 1 = ready pin pulled low, 0 = released |
| overrun_o | output | 1 | Sticky: start arrived while busy |
| coarse_err_o | output | 1 | Coarse code was not monotonic |
| fine_err_o | output | 1 | Fine code was not monotonic |

## Verification
The embedded properties check the following on every cycle:
- an accepted start enters tracking with a cleared counter;
- the interrupt sets on the fine capture and clears on a strobe edge;
- the ready flag is released at end of conversion;
- the overrun flag stays set;
- the multiplexer select holds when a start arrives while busy.

Some behaviour only the directed scenarios can show:
- the exact capture edges;
- the encoded values for valid, boundary and broken thermometer codes;
- the split between pipelined and wait-state reads on the bus;
- the single-cycle recovery boundary.

The bench's comparator model follows mux_sel_o, so a wrong channel latch shows up as a wrong result.

// File: rtl/hf_adc_pkg.sv
package hf_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRACK,
    ST_FINE,
    ST_RECOV
  } conv_state_e;
endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
  parameter int NIB_W = 4,
  localparam int COMP_N = (1 << NIB_W) - 1
) (
  input  logic [COMP_N-1:0] therm_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              err_o
);
  logic [NIB_W-1:0]  ones;
  logic [COMP_N-1:0] ideal;

  always_comb begin
    ones = '0;
    for (int i = 0; i < COMP_N; i++) ones = ones + NIB_W'(therm_i[i]);
    for (int i = 0; i < COMP_N; i++) ideal[i] = (ones > NIB_W'(i));
  end

  assign nib_o = ones;
  assign err_o = (therm_i != ideal);
endmodule

// File: rtl/hf_conv_fsm.sv
module hf_conv_fsm
  import hf_adc_pkg::*;
#(
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60,
  parameter int RECOV_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic conv_o,
  output logic coarse_lat_o,
  output logic fine_lat_o
);
  localparam int MAX_A   = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
  localparam int MAX_CYC = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  conv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             recov_done;

  assign coarse_lat_o = (state_q == ST_TRACK) && (cnt_q == CNT_W'(TRACK_CYC - 1));
  assign fine_lat_o   = (state_q == ST_FINE)  && (cnt_q == CNT_W'(FINE_CYC - 1));
  assign recov_done   = (state_q == ST_RECOV) && (cnt_q == CNT_W'(RECOV_CYC - 1));
  assign busy_o       = (state_q != ST_IDLE);
  assign conv_o       = (state_q == ST_TRACK) || (state_q == ST_FINE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_TRACK;
          cnt_q   <= '0;
        end
        ST_TRACK: if (coarse_lat_o) begin
          state_q <= ST_FINE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ST_FINE: if (fine_lat_o) begin
          state_q <= ST_RECOV;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: if (recov_done) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  p_start_track_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == ST_IDLE) |=> (state_q == ST_TRACK && cnt_q == '0));
endmodule

// File: rtl/hf_adc_seq.sv
module hf_adc_seq #(
  parameter int NIB_W     = 4,
  parameter int CH_W      = 3,
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60,
  parameter int RECOV_CYC = 50,
  parameter int PIPE_WIN  = 8,
  localparam int COMP_N   = (1 << NIB_W) - 1,
  localparam int DATA_W   = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic [CH_W-1:0]   addr_i,
  input  logic [COMP_N-1:0] coarse_therm_i,
  input  logic [COMP_N-1:0] fine_therm_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              int_no,
  output logic              rdy_low_o,
  output logic              overrun_o,
  output logic              coarse_err_o,
  output logic              fine_err_o
);
  localparam int RC_W = $clog2(PIPE_WIN + 1);

  logic cs_q, rd_q, strobe, strobe_q, start_evt, accept;
  logic cs_rise, cs_fall, rd_rise;
  logic busy, conv, coarse_lat, fine_lat;
  logic [1:0][COMP_N-1:0] therm_s;
  logic [1:0][NIB_W-1:0]  nib_s;
  logic [1:0]             err_s;
  logic [DATA_W-1:0]      res_q;
  logic [RC_W-1:0]        rd_cnt_q;
  logic                   eoc_q;

  assign strobe    = !cs_ni && !rd_ni;
  assign strobe_q  = !cs_q && !rd_q;
  assign start_evt = strobe && !strobe_q;
  assign accept    = start_evt && !busy;
  assign cs_rise   = cs_ni && !cs_q;
  assign cs_fall   = !cs_ni && cs_q;
  assign rd_rise   = rd_ni && !rd_q;

  hf_conv_fsm #(
    .TRACK_CYC(TRACK_CYC), .FINE_CYC(FINE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i(start_evt), .busy_o(busy), .conv_o(conv),
    .coarse_lat_o(coarse_lat), .fine_lat_o(fine_lat)
  );

  assign therm_s[0] = coarse_therm_i;
  assign therm_s[1] = fine_therm_i;

  for (genvar g = 0; g < 2; g++) begin : g_stage
    hf_therm_enc #(.NIB_W(NIB_W)) u_enc (
      .therm_i(therm_s[g]), .nib_o(nib_s[g]), .err_o(err_s[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q         <= 1'b1;
      rd_q         <= 1'b1;
      mux_sel_o    <= '0;
      res_q        <= '0;
      coarse_err_o <= 1'b0;
      fine_err_o   <= 1'b0;
      overrun_o    <= 1'b0;
      eoc_q        <= 1'b0;
      rdy_low_o    <= 1'b0;
      rd_cnt_q     <= '0;
    end else begin
      cs_q <= cs_ni;
      rd_q <= rd_ni;
      if (accept) begin
        mux_sel_o    <= addr_i;
        coarse_err_o <= 1'b0;
        fine_err_o   <= 1'b0;
      end
      if (start_evt && busy) overrun_o <= 1'b1;
      if (coarse_lat) begin
        res_q[DATA_W-1:NIB_W] <= nib_s[0];
        coarse_err_o          <= err_s[0];
      end
      if (fine_lat) begin
        res_q[NIB_W-1:0] <= nib_s[1];
        fine_err_o       <= err_s[1];
      end
      if (fine_lat) eoc_q <= 1'b1;
      else if (cs_rise || rd_rise) eoc_q <= 1'b0;
      if (cs_fall) rdy_low_o <= 1'b1;
      else if (cs_rise || fine_lat) rdy_low_o <= 1'b0;
      if (!strobe) rd_cnt_q <= '0;
      else if (rd_cnt_q != RC_W'(PIPE_WIN)) rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  // a long strobe during conversion is a wait-state read: hide the bus
  assign data_oe_o = strobe && !(conv && rd_cnt_q == RC_W'(PIPE_WIN));
  assign data_o    = res_q;
  assign int_no    = !eoc_q;

  p_int_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_lat |=> !int_no);
  p_int_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_ni && !cs_q) && !fine_lat) |=> int_no);
  p_rdy_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_lat && !(!cs_ni && cs_q)) |=> !rdy_low_o);
  p_overrun_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  p_mux_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt && busy) |=> $stable(mux_sel_o));
endmodule

// File: tb/hf_adc_seq_bench.sv
module hf_adc_seq_bench;
  localparam int T   = 100;
  localparam int F   = 60;
  localparam int R   = 50;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [14:0] c_therm, f_therm;
  logic [2:0]  mux_sel;
  logic [7:0]  data;
  logic        oe, int_n, rdy_low, overrun, c_err, f_err;
  logic [7:0]  chan_val [8];
  logic        bad_c = 1'b0, bad_f = 1'b0;
  int          checks = 0, errors = 0;

  always #4 clk = !clk;

  function automatic logic [14:0] therm(input logic [3:0] k);
    return (15'(1) << k) - 15'(1);
  endfunction

  always_comb begin
    c_therm = bad_c ? 15'h0005 : therm(chan_val[mux_sel][7:4]);
    f_therm = bad_f ? 15'h4001 : therm(chan_val[mux_sel][3:0]);
  end

  hf_adc_seq #(
    .TRACK_CYC(T), .FINE_CYC(F), .RECOV_CYC(R), .PIPE_WIN(WIN)
  ) u_hf_adc_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .addr_i(addr),
    .coarse_therm_i(c_therm), .fine_therm_i(f_therm), .mux_sel_o(mux_sel),
    .data_o(data), .data_oe_o(oe), .int_no(int_n), .rdy_low_o(rdy_low),
    .overrun_o(overrun), .coarse_err_o(c_err), .fine_err_o(f_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe_on(input logic [2:0] a);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
  endtask

  task automatic strobe_off();
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R11 oe", oe, 0);
    chk("R11 int_n", int_n, 1);
    chk("R11 rdy", rdy_low, 0);
    chk("R11 flags", {overrun, c_err, f_err}, 0);
    chk("R11 mux", mux_sel, 0);
    chk("R11 result", data, 0);
  endtask

  task automatic t_wait_read();
    strobe_on(3'd3);
    tick(1);
    chk("R6 rdy low on cs fall", rdy_low, 1);
    chk("R1 mux latched", mux_sel, 3);
    addr = 3'd5;
    tick(WIN);
    chk("R7 bus hidden", oe, 0);
    chk("R1 mux held", mux_sel, 3);
    tick(T + F - 1 - WIN);
    chk("R2 no eoc yet", int_n, 1);
    chk("R7 still hidden", oe, 0);
    tick(1);
    chk("R5 eoc", int_n, 0);
    chk("R7 bus back", oe, 1);
    chk("R2 result", data, 8'hA5);
    chk("R6 released at eoc", rdy_low, 0);
    strobe_off();
    tick(1);
    chk("R5 int cleared", int_n, 1);
    tick(R + 2);
  endtask

  task automatic t_pipe_read();
    strobe_on(3'd6);
    chk("R8 oe", oe, 1);
    chk("R8 previous", data, 8'hA5);
    tick(1);
    strobe_off();
    tick(1);
    chk("R6 released on cs rise", rdy_low, 0);
    tick(T + F - 2);
    chk("R2 no eoc yet", int_n, 1);
    tick(1);
    chk("R5 eoc", int_n, 0);
    tick(R + 2);
  endtask

  task automatic t_overrun();
    strobe_on(3'd0);
    chk("R8 previous", data, 8'h3C);
    tick(1);
    strobe_off();
    tick(20);
    chk("R9 no overrun yet", overrun, 0);
    strobe_on(3'd7);
    tick(1);
    chk("R9 overrun", overrun, 1);
    chk("R9 mux kept", mux_sel, 0);
    strobe_off();
    tick(T + F + R + 5);
    chk("R9 sticky", overrun, 1);
  endtask

  task automatic t_bounds();
    strobe_on(3'd1);
    chk("R3 all-clear code", data, 8'h00);
    tick(1);
    strobe_off();
    tick(T + F + R + 5);
    bad_c = 1'b1;
    strobe_on(3'd2);
    chk("R3 all-set code", data, 8'hFF);
    tick(1);
    strobe_off();
    tick(T + F + R + 5);
    bad_c = 1'b0;
    chk("R4 coarse err", c_err, 1);
    chk("R4 fine ok", f_err, 0);
    bad_f = 1'b1;
    strobe_on(3'd2);
    chk("R4 popcount nibble", data, 8'h2B);
    tick(1);
    chk("R4 err cleared", c_err, 0);
    strobe_off();
  endtask

  task automatic t_recovery();
    // previous start sampled one edge before the last negedge
    tick(T + F + R - 1);
    bad_f = 1'b0;
    chk("R4 fine err", f_err, 1);
    chk("R4 fine popcount", data[3:0], 2);
    strobe_on(3'd4);
    tick(1);
    chk("R10 ignored at boundary", mux_sel, 2);
    strobe_off();
    tick(1);
    strobe_on(3'd4);
    tick(1);
    chk("R10 accepted after", mux_sel, 4);
    strobe_off();
  endtask

  initial begin
    chan_val[0] = 8'h00; chan_val[1] = 8'hFF; chan_val[2] = 8'h5B;
    chan_val[3] = 8'hA5; chan_val[4] = 8'h11; chan_val[5] = 8'h77;
    chan_val[6] = 8'h3C; chan_val[7] = 8'hE2;
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_wait_read();
    t_pipe_read();
    t_overrun();
    t_bounds();
    t_recovery();
    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule